// File: doc/BRIEF.md
# Four-Phase Interrupt Entry Sequencer

This block sits beside the fetch/execute pipeline of a small processor core whose instruction cycle is split into four clock phases, Q1 to Q4, each marked by a one-hot strobe. It watches an asynchronous external interrupt pin and sets a pending flag when the selected edge arrives. It holds an 8-bit interrupt control register that software reads and writes, and it combines the pin flag with two software-set flags, a gated peripheral request and a global enable into one request.

The request is looked at once per instruction cycle, on the Q1 strobe. When it is seen, the sequencer runs a fixed entry: the rest of the current instruction cycle completes, then two dummy instruction cycles follow. In these cycles the fetch address is overridden to the vector and then the vector plus one, the pipeline is flushed, and the return address is pushed. The first vector instruction executes in the third cycle after detection. The latency does not depend on how long the interrupted instruction is. A return strobe pops the return address and turns the global enable back on. A flag that is still set then causes a fresh entry.

Top module: `qint_entry_seq`

## Requirements
- R1: After reset the control register reads 0x00, and `dummy_o`, `flush_o`, `fetch_ovr_o`, `push_stb_o` and `pop_stb_o` are low.
- R2: Control register fields: bit 7 global enable, bit 6 peripheral enable, bit 5 timer enable, bit 4 pin enable, bit 3 port-change enable, bit 2 timer flag, bit 1 pin flag, bit 0 port-change flag. When no hardware event occurs, a written value reads back unchanged.
- R3: With `edge_rise_i`=1 a rising pin edge sets bit 1; with `edge_rise_i`=0 a falling edge sets it. The opposite edge leaves the register unchanged.
- R4: After a two-flop synchronizer, an edge recognised at a Q4 or Q1 clock sets the pin flag on that clock edge. An edge recognised at Q2 or Q3 is held and sets the flag on the next Q4 clock edge.
- R5: The request is: global enable AND (pin enable·pin flag OR timer enable·timer flag OR port enable·port flag OR peripheral enable·`periph_req_i`). With any term missing, no entry occurs.
- R6: The request is sampled only at Q1 clock edges. After a true sample, `dummy_o` and `fetch_ovr_o` are high for the next two full instruction cycles, each starting at a Q1 phase. `fetch_addr_o` is 0x0004 in the first cycle and 0x0005 in the second. `flush_o` is high in the first cycle only.
- R7: Taking an entry clears the global enable bit.
- R8: `push_stb_o` pulses for one clock at the Q1 phase of the first dummy cycle, with `push_addr_o` equal to `pc_i` at the sampling edge plus one.
- R9: A `reti_i` pulse sets the global enable bit, and `pop_stb_o` is high on the following clock. A flag that is still enabled and set then triggers a new entry.
- R10: No entry is sampled from the detecting Q1 edge through the end of the second dummy cycle. A request pending at that point is taken at the first Q1 edge after the window.
- R11: If the pin flag is set by hardware in the same clock as a software write that clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| phase_stb_i | input | 4 | One-hot phase strobe, bit 0 = Q1 ... bit 3 = Q4 |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| edge_rise_i | input | 1 | 1 = rising edge active, 0 = falling |
| icr_wr_en_i | input | 1 | Control register write strobe |
| icr_wr_data_i | input | 8 | Control register write data |
| icr_rd_data_o | output | 8 | Control register contents |
| periph_req_i | input | 1 | Combined peripheral interrupt request |
| pc_i | input | PC_W | Program counter of the current flow |
| reti_i | input | 1 | Return-from-interrupt strobe |
| dummy_o | output | 1 | Execute slot is a dummy cycle |
| flush_o | output | 1 | Discard the prefetched instruction |
| fetch_ovr_o | output | 1 | Fetch from `fetch_addr_o` instead of the PC |
| fetch_addr_o | output | PC_W | Vector fetch address |
| push_stb_o | output | 1 | Push the return address |
| push_addr_o | output | PC_W | Return address to push |
| pop_stb_o | output | 1 | Pop the return address |

## Verification
A pin edge that sets the flag and a software write that clears the flag can land on the same clock. The bench provokes this by changing the pin two clocks before a Q1 edge, so that the synchronized edge is recognised at that Q1 edge, and by issuing a write of 0x10 in the same clock. The flag must read back as set. A second pairing puts a return strobe inside the dummy window with the flag still set. Here the judgment is that the window ends on time and re-entry waits until after it.

// File: rtl/qint_pkg.sv
package qint_pkg;
  localparam int unsigned ICR_W = 8;
  // control register bit positions
  localparam int unsigned B_GEN = 7;
  localparam int unsigned B_PEN = 6;
  localparam int unsigned B_TEN = 5;
  localparam int unsigned B_XEN = 4;
  localparam int unsigned B_CEN = 3;
  localparam int unsigned B_TFL = 2;
  localparam int unsigned B_XFL = 1;
  localparam int unsigned B_CFL = 0;
  localparam int unsigned N_PH  = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_DUMMY1 = 2'd2,
    SEQ_DUMMY2 = 2'd3
  } seq_state_e;
endpackage

// File: rtl/qint_pin_sync.sv
module qint_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_first
      assign d = pin_i;
    end else begin : g_next
      assign d = chain_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) chain_q[g] <= 1'b0;
      else          chain_q[g] <= d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) last_q <= 1'b0;
    else          last_q <= chain_q[TOP];
  end

  assign edge_o = rise_sel_i ? (chain_q[TOP] & ~last_q) : (~chain_q[TOP] & last_q);

  // R3: a recognised edge lasts exactly one clock
  p_edge_single_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    edge_o |=> !edge_o);
endmodule

// File: rtl/qint_ctrl_reg.sv
module qint_ctrl_reg
  import qint_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [N_PH-1:0]  phase_i,
  input  logic             edge_i,
  input  logic             wr_en_i,
  input  logic [ICR_W-1:0] wr_data_i,
  input  logic             take_i,
  input  logic             reti_i,
  input  logic             periph_req_i,
  output logic [ICR_W-1:0] icr_o,
  output logic             irq_o
);
  logic [ICR_W-1:0] icr_q, icr_d;
  logic             pend_q, pend_d;
  logic             set_x, icr_en;
  logic             q1, q2, q3, q4;

  assign q1 = phase_i[0];
  assign q2 = phase_i[1];
  assign q3 = phase_i[2];
  assign q4 = phase_i[3];

  always_comb begin
    // edges seen mid-cycle wait for the Q4 edge
    pend_d = pend_q;
    if (q4)                     pend_d = 1'b0;
    else if (edge_i & (q2 | q3)) pend_d = 1'b1;

    set_x = (edge_i & (q4 | q1)) | (pend_q & q4);

    icr_d = icr_q;
    if (wr_en_i) icr_d = wr_data_i;
    if (reti_i)  icr_d[B_GEN] = 1'b1;
    if (take_i)  icr_d[B_GEN] = 1'b0;
    if (set_x)   icr_d[B_XFL] = 1'b1;   // hardware set beats software clear

    icr_en = wr_en_i | reti_i | take_i | set_x;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    icr_q <= '0;
    else if (icr_en) icr_q <= icr_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) pend_q <= 1'b0;
    else          pend_q <= pend_d;
  end

  assign icr_o = icr_q;
  assign irq_o = icr_q[B_GEN] & ((icr_q[B_XEN] & icr_q[B_XFL]) |
                                 (icr_q[B_TEN] & icr_q[B_TFL]) |
                                 (icr_q[B_CEN] & icr_q[B_CFL]) |
                                 (icr_q[B_PEN] & periph_req_i));

  // R7: entry leaves global enable cleared
  p_gie_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    take_i |=> !icr_q[B_GEN]);
  // R11: a hardware set is never lost
  p_flag_set_r11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    set_x |=> icr_q[B_XFL]);
  // R4: without a write, the pin flag rises only from a Q4 or Q1 edge
  p_flag_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($rose(icr_q[B_XFL]) && !$past(wr_en_i)) |-> $past(q4 | q1));
endmodule

// File: rtl/qint_entry_fsm.sv
module qint_entry_fsm
  import qint_pkg::*;
#(
  parameter int unsigned PC_W     = 13,
  parameter int unsigned VEC_ADDR = 4
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            q1_i,
  input  logic            q4_i,
  input  logic            irq_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            reti_i,
  output logic            take_o,
  output logic            dummy_o,
  output logic            flush_o,
  output logic            fetch_ovr_o,
  output logic [PC_W-1:0] fetch_addr_o,
  output logic            push_stb_o,
  output logic [PC_W-1:0] push_addr_o,
  output logic            pop_stb_o
);
  localparam logic [PC_W-1:0] VEC0 = PC_W'(VEC_ADDR);
  localparam logic [PC_W-1:0] VEC1 = PC_W'(VEC_ADDR + 1);

  seq_state_e      state_q, state_d;
  logic            state_en;
  logic [PC_W-1:0] ret_q;
  logic            pop_q;

  assign take_o = q1_i & irq_i & (state_q == SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (take_o) state_d = SEQ_ARMED;
      SEQ_ARMED:  if (q4_i)   state_d = SEQ_DUMMY1;
      SEQ_DUMMY1: if (q4_i)   state_d = SEQ_DUMMY2;
      SEQ_DUMMY2: if (q4_i)   state_d = SEQ_IDLE;
      default:                state_d = SEQ_IDLE;
    endcase
    state_en = take_o | q4_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)      state_q <= SEQ_IDLE;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    ret_q <= '0;
    else if (take_o) ret_q <= pc_i + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) pop_q <= 1'b0;
    else          pop_q <= reti_i;
  end

  assign dummy_o      = (state_q == SEQ_DUMMY1) | (state_q == SEQ_DUMMY2);
  assign fetch_ovr_o  = dummy_o;
  assign flush_o      = (state_q == SEQ_DUMMY1);
  assign fetch_addr_o = (state_q == SEQ_DUMMY2) ? VEC1 : VEC0;
  assign push_stb_o   = (state_q == SEQ_DUMMY1) & q1_i;
  assign push_addr_o  = ret_q;
  assign pop_stb_o    = pop_q;

  // R6: the dummy window opens on a Q1 phase
  p_window_start_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(dummy_o) |-> q1_i);
  // R8: the return address is pushed as the window opens
  p_push_first_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(dummy_o) |-> push_stb_o);
  // R6: the second dummy cycle fetches the vector plus one
  p_vec_order_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (fetch_ovr_o && $past(fetch_ovr_o) && q1_i) |-> (fetch_addr_o == VEC1));
endmodule

// File: rtl/qint_entry_seq.sv
module qint_entry_seq
  import qint_pkg::*;
#(
  parameter int unsigned PC_W        = 13,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_ADDR    = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [N_PH-1:0]  phase_stb_i,
  input  logic             ext_pin_i,
  input  logic             edge_rise_i,
  input  logic             icr_wr_en_i,
  input  logic [ICR_W-1:0] icr_wr_data_i,
  output logic [ICR_W-1:0] icr_rd_data_o,
  input  logic             periph_req_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             reti_i,
  output logic             dummy_o,
  output logic             flush_o,
  output logic             fetch_ovr_o,
  output logic [PC_W-1:0]  fetch_addr_o,
  output logic             push_stb_o,
  output logic [PC_W-1:0]  push_addr_o,
  output logic             pop_stb_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       pin_edge, take, irq;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  qint_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .pin_i      (ext_pin_i),
    .rise_sel_i (edge_rise_i),
    .edge_o     (pin_edge)
  );

  qint_ctrl_reg i_ctrl (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n),
    .phase_i      (phase_stb_i),
    .edge_i       (pin_edge),
    .wr_en_i      (icr_wr_en_i),
    .wr_data_i    (icr_wr_data_i),
    .take_i       (take),
    .reti_i       (reti_i),
    .periph_req_i (periph_req_i),
    .icr_o        (icr_rd_data_o),
    .irq_o        (irq)
  );

  qint_entry_fsm #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) i_fsm (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n),
    .q1_i         (phase_stb_i[0]),
    .q4_i         (phase_stb_i[3]),
    .irq_i        (irq),
    .pc_i         (pc_i),
    .reti_i       (reti_i),
    .take_o       (take),
    .dummy_o      (dummy_o),
    .flush_o      (flush_o),
    .fetch_ovr_o  (fetch_ovr_o),
    .fetch_addr_o (fetch_addr_o),
    .push_stb_o   (push_stb_o),
    .push_addr_o  (push_addr_o),
    .pop_stb_o    (pop_stb_o)
  );

  // R6: phase strobes arrive one at a time
  p_phase_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(phase_stb_i));
  // R1: nothing leaves the block while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_n |-> (!dummy_o && !push_stb_o && icr_rd_data_o == '0));
endmodule

// File: tb/test_qint_entry_seq.sv
module test_qint_entry_seq;
  localparam int PC_W = 13;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      ph;
  logic [3:0]      phase_stb;
  logic            pin, rise, wr_en, periph, reti;
  logic [7:0]      wr_data, icr;
  logic [PC_W-1:0] pc, fetch_addr, push_addr;
  logic            dummy, flush, fovr, push, pop;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 2'd0;
    else        ph <= ph + 2'd1;
  end
  assign phase_stb = 4'b0001 << ph;

  qint_entry_seq #(.PC_W(PC_W)) i_qint_entry_seq (
    .clk_i(clk), .rst_n_i(rst_n), .phase_stb_i(phase_stb), .ext_pin_i(pin),
    .edge_rise_i(rise), .icr_wr_en_i(wr_en), .icr_wr_data_i(wr_data),
    .icr_rd_data_o(icr), .periph_req_i(periph), .pc_i(pc), .reti_i(reti),
    .dummy_o(dummy), .flush_o(flush), .fetch_ovr_o(fovr),
    .fetch_addr_o(fetch_addr), .push_stb_o(push), .push_addr_o(push_addr),
    .pop_stb_o(pop)
  );

  // {init[20:13], rise[12], idle[11], to[10], periph[9], entry[8], icr_after[7:0]}
  localparam logic [20:0] VECS [10] = '{
    {8'h90, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h12},  // R3 rising taken
    {8'h90, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h12},  // R3 falling taken
    {8'h90, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h90},  // R3 wrong edge ignored
    {8'h10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h12},  // R5 no global enable
    {8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h82},  // R5 no pin enable
    {8'hA4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h24},  // R5 timer flag
    {8'h84, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h84},  // R5 timer not enabled
    {8'h89, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h09},  // R5 port flag
    {8'hC0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h40},  // R5 peripheral gated on
    {8'h80, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80}   // R5 peripheral gated off
  };

  function automatic string vtag(input int i);
    return (i < 3) ? "R3" : "R5";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ph(input logic [1:0] p);
    while (ph != p) @(negedge clk);
  endtask

  task automatic write_icr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic count_dummy(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      step();
      if (dummy) cnt++;
    end
  endtask

  initial begin
    int cnt;
    rst_n = 1'b0; pin = 1'b0; rise = 1'b1; wr_en = 1'b0; wr_data = '0;
    periph = 1'b0; reti = 1'b0; pc = 13'h123;
    step(4);
    chk("R1 icr in reset", icr, 8'h00);
    rst_n = 1'b1;
    step(3);
    chk("R1 icr after reset", icr, 8'h00);
    chk("R1 outputs quiet", {dummy, flush, fovr, push, pop}, 5'b0);

    // R2 readback, no global enable so no entry
    write_icr(8'h5A);
    step();
    chk("R2 readback", icr, 8'h5A);
    write_icr(8'h00);

    // table walk
    for (int i = 0; i < 10; i++) begin
      logic [20:0] v;
      v = VECS[i];
      rise = v[12]; pin = v[11]; periph = 1'b0;
      step(12);
      write_icr(v[20:13]);
      pin = v[10]; periph = v[9];
      count_dummy(40, cnt);
      chk({vtag(i), " dummy clocks"}, cnt, v[8] ? 8 : 0);
      chk({vtag(i), " icr after"}, icr, v[7:0]);
      periph = 1'b0;
    end

    // R6 / R8: exact synchronous timing through the timer flag
    write_icr(8'h00);
    step(4);
    wait_ph(2'd1);
    write_icr(8'hA4);            // lands on a Q2 edge
    step(5);
    chk("R6 no dummy before window", dummy, 0);
    step();
    chk("R6 first dummy", dummy, 1);
    chk("R6 flush first", flush, 1);
    chk("R6 fetch override", fovr, 1);
    chk("R6 vector addr", fetch_addr, 13'h004);
    chk("R8 push strobe", push, 1);
    chk("R8 push addr", push_addr, 13'h124);
    chk("R7 gie cleared", icr[7], 0);
    step();
    chk("R8 push single clock", push, 0);
    step(3);
    chk("R6 second dummy", dummy, 1);
    chk("R6 vector plus one", fetch_addr, 13'h005);
    chk("R6 flush only first", flush, 0);
    step(4);
    chk("R6 window closed", {dummy, fovr}, 2'b00);

    // R4: deferred set through Q2
    write_icr(8'h10); rise = 1'b1; pin = 1'b0;
    step(12);
    wait_ph(2'd3);
    pin = 1'b1;
    step(4);
    chk("R4 held until Q4", icr[1], 0);
    step();
    chk("R4 set on Q4", icr[1], 1);

    // R11 + R4 direct: edge recognised at Q1 while software clears
    pin = 1'b0;
    step(12);
    write_icr(8'h10);
    step(4);
    wait_ph(2'd2);
    pin = 1'b1;
    step(2);
    chk("R4 not set before Q1", icr[1], 0);
    wr_en = 1'b1; wr_data = 8'h10;
    step();
    wr_en = 1'b0;
    chk("R11 set beats clear", icr, 8'h12);

    // R9: return with flag still set re-enters
    pin = 1'b0;
    step(12);
    write_icr(8'h90);
    pin = 1'b1;
    count_dummy(40, cnt);
    chk("R9 setup entry", cnt, 8);
    reti = 1'b1;
    step();
    reti = 1'b0;
    chk("R9 pop strobe", pop, 1);
    chk("R9 gie set", icr[7], 1);
    count_dummy(30, cnt);
    chk("R9 retrigger", cnt, 8);

    // R10: return inside the window does not extend it
    reti = 1'b1;
    step();
    reti = 1'b0;
    cnt = 0;
    while (!dummy && cnt < 30) begin step(); cnt++; end
    reti = 1'b1;
    step();
    reti = 1'b0;
    step(7);
    chk("R10 window ends on time", dummy, 0);
    chk("R10 gie pending", icr[7], 1);
    step(4);
    chk("R10 entry after window", dummy, 1);
    step(8);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule